// File: doc/BRIEF.md
# Predicated Add/Subtract Unit with Zero and Carry Flags

This block is the arithmetic stage of a small load-store processor. Each operation code has two parts. One part picks one of four add or subtract kinds. The other part is a condition, tested against the current Zero and Carry flags, that decides whether the operation takes effect. When the condition holds, the unit produces the result, asks for a register write and passes on fresh flag values. When the condition fails, the write request stays low and the incoming flags pass through unchanged. Conditional code can therefore run without branches.

The caller supplies two operands, the operation code, the current flags and a valid strobe. All outputs are registered and appear one clock after the inputs are sampled. Operand fetch and the register file sit outside the block.

Top module: `pred_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `res` = 0, `wb_en` = 0, `z_next` = 0 and `c_next` = 0.
- R2: `op` bits [4:2] hold the condition and bits [1:0] hold the kind: 00 add, 01 subtract, 10 add with carry, 11 subtract with carry. Results appear on the outputs one clock after the inputs are sampled.
- R3: Add gives `a + b` and add with carry gives `a + b + c_in`. For both, `c_next` is the carry out of the top bit.
- R4: Subtract gives `a - b` and subtract with carry gives `a - b - (1 - c_in)`. For both, `c_next` is 1 when no borrow occurs.
- R5: When an operation executes, `z_next` is 1 exactly when the WIDTH-bit result is all zeros.
- R6: Condition 000 always executes, 001 executes only when `z_in` = 1, 010 only when `z_in` = 0, and 011 only when `c_in` = 1. An executed operation raises `wb_en` for one cycle.
- R7: Conditions 100 to 111 never execute.
- R8: When an operation does not execute, `wb_en` = 0, `z_next` and `c_next` equal the sampled `z_in` and `c_in`, and `res` keeps its previous value.
- R9: With `vld` low, nothing executes, whatever the condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld | input | 1 | Operation valid |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| op | input | 5 | Condition [4:2] and kind [1:0] |
| z_in | input | 1 | Current Zero flag |
| c_in | input | 1 | Current Carry flag |
| res | output | WIDTH | Registered result |
| wb_en | output | 1 | Register write request |
| z_next | output | 1 | Next Zero flag |
| c_next | output | 1 | Next Carry flag |

## Verification
The bench builds the unit with the default WIDTH of 16, so carry and borrow come out of bit 15. With that width the edge cases are directed operands: 0xFFFF + 1 wrapping to zero, subtracting equal values, and borrows that leave the result all ones. Random operands, codes and flags then cover all 32 operation codes under every combination of the two flags, including the four reserved conditions and the cycles where the valid strobe is low.

// File: rtl/pred_alu_pkg.sv
package pred_alu_pkg;
  localparam int OP_W   = 5;
  localparam int COND_W = 3;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    K_ADD = 2'b00,
    K_SUB = 2'b01,
    K_ADC = 2'b10,
    K_SBC = 2'b11
  } kind_e;

  typedef enum logic [COND_W-1:0] {
    C_ALWAYS = 3'b000,
    C_ZSET   = 3'b001,
    C_ZCLR   = 3'b010,
    C_CSET   = 3'b011
  } cond_e;
endpackage

// File: rtl/pred_alu_gate.sv
module pred_alu_gate
  import pred_alu_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic              zf,
  input  logic              cf,
  output logic              go
);
  always_comb begin
    unique case (cond)
      C_ALWAYS: go = 1'b1;
      C_ZSET:   go = zf;
      C_ZCLR:   go = ~zf;
      C_CSET:   go = cf;
      default:  go = 1'b0;  // reserved codes never run
    endcase
  end
endmodule

// File: rtl/pred_alu_core.sv
module pred_alu_core
  import pred_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  kind_e            kind,
  input  logic             cf,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int EXT_W = WIDTH + 1;

  logic             is_sub;
  logic             cin_eff;
  logic [WIDTH-1:0] y_eff;
  logic [EXT_W-1:0] ext;

  always_comb begin
    is_sub = (kind == K_SUB) || (kind == K_SBC);
    unique case (kind)
      K_ADD:   cin_eff = 1'b0;
      K_SUB:   cin_eff = 1'b1;
      default: cin_eff = cf;
    endcase
    y_eff = is_sub ? ~y : y;
    ext   = {1'b0, x} + {1'b0, y_eff} + {{WIDTH{1'b0}}, cin_eff};
    sum   = ext[WIDTH-1:0];
    cout  = ext[WIDTH];
  end
endmodule

// File: rtl/pred_alu.sv
module pred_alu
  import pred_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [OP_W-1:0]  op,
  input  logic             z_in,
  input  logic             c_in,
  output logic [WIDTH-1:0] res,
  output logic             wb_en,
  output logic             z_next,
  output logic             c_next
);
  logic             cond_ok;
  logic             fire;
  logic [WIDTH-1:0] sum;
  logic             cout;

  pred_alu_gate u_gate (
    .cond (op[OP_W-1:KIND_W]),
    .zf   (z_in),
    .cf   (c_in),
    .go   (cond_ok)
  );

  pred_alu_core #(.WIDTH(WIDTH)) u_core (
    .x    (a),
    .y    (b),
    .kind (kind_e'(op[KIND_W-1:0])),
    .cf   (c_in),
    .sum  (sum),
    .cout (cout)
  );

  assign fire = vld & cond_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      res    <= '0;
      wb_en  <= 1'b0;
      z_next <= 1'b0;
      c_next <= 1'b0;
    end else if (fire) begin
      res    <= sum;
      wb_en  <= 1'b1;
      z_next <= (sum == '0);
      c_next <= cout;
    end else begin
      wb_en  <= 1'b0;
      z_next <= z_in;
      c_next <= c_in;
    end
  end

  // R1: the cycle after reset shows the cleared state
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (res == '0 && !wb_en && !z_next && !c_next));

  // R5: an executed operation flags zero exactly for an all-zero result
  a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (z_next == (res == '0)));

  // R6: unconditional codes always write
  a_r6_always_runs: assert property (@(posedge clk) disable iff (rst)
    (vld && op[OP_W-1:KIND_W] == 3'b000) |=> wb_en);

  // R7: reserved conditions never write
  a_r7_reserved_idle: assert property (@(posedge clk) disable iff (rst)
    (vld && op[OP_W-1]) |=> !wb_en);

  // R9 / R8: an idle cycle passes flags through and holds the result
  a_r9_idle_pass: assert property (@(posedge clk) disable iff (rst)
    !vld |=> (!wb_en && z_next == $past(z_in) && c_next == $past(c_in)
              && $stable(res)));

  // R8: a write request always follows a valid operation
  a_r8_wb_needs_vld: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> $past(vld));
endmodule

// File: tb/pred_alu_bench.sv
module pred_alu_bench;
  localparam int W = 16;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst;
  logic         vld;
  logic [W-1:0] a, b;
  logic [4:0]   op;
  logic         z_in, c_in;
  logic [W-1:0] res;
  logic         wb_en, z_next, c_next;

  int checks = 0;
  int failures = 0;

  int exp_res = 0;
  bit exp_wb, exp_z, exp_c;
  string tag;

  always #5 clk = ~clk;

  pred_alu #(.WIDTH(W)) u_pred_alu (
    .clk(clk), .rst(rst), .vld(vld), .a(a), .b(b), .op(op),
    .z_in(z_in), .c_in(c_in), .res(res), .wb_en(wb_en),
    .z_next(z_next), .c_next(c_next)
  );

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  // behavioural reference: computes next outputs from sampled inputs
  task automatic model(input bit r, input bit v, input int x, input int y,
                       input int o, input bit zf, input bit cf);
    int cond = o >> 2;
    int kind = o & 3;
    bit run;
    int s;
    if (r) begin
      exp_res = 0; exp_wb = 0; exp_z = 0; exp_c = 0; tag = "R1";
      return;
    end
    case (cond)
      0: run = 1;
      1: run = zf;
      2: run = !zf;
      3: run = cf;
      default: run = 0;
    endcase
    if (!v) begin
      run = 0; tag = "R9";
    end else if (cond >= 4) tag = "R7";
    else if (!run) tag = "R8";
    else if (cond != 0) tag = "R6";
    else tag = (kind == 0 || kind == 2) ? "R3" : "R4";
    if (!run) begin
      exp_wb = 0; exp_z = zf; exp_c = cf;
      return;
    end
    case (kind)
      0: s = x + y;
      1: s = x - y;
      2: s = x + y + int'(cf);
      default: s = x - y - (1 - int'(cf));
    endcase
    if (kind == 0 || kind == 2) exp_c = ((s >> W) & 1) != 0;
    else exp_c = (s >= 0);
    exp_res = s & MASK;
    exp_z = (exp_res == 0);
    exp_wb = 1;
  endtask

  task automatic step(input bit r, input bit v, input int x, input int y,
                      input int o, input bit zf, input bit cf);
    @(negedge clk);
    rst = r; vld = v; a = W'(x); b = W'(y); op = 5'(o); z_in = zf; c_in = cf;
    model(r, v, x, y, o, zf, cf);
    @(posedge clk);
    #1;
    chk(tag, "res (R2 timing)", int'(res), exp_res);
    chk(tag, "wb_en", int'(wb_en), int'(exp_wb));
    chk(exp_wb ? "R5" : tag, "z_next", int'(z_next), int'(exp_z));
    chk(tag, "c_next", int'(c_next), int'(exp_c));
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1; vld = 0; a = 0; b = 0; op = 0; z_in = 0; c_in = 0;
    // R1: reset state
    step(1, 1, 5, 6, 0, 1, 1);
    step(1, 0, 0, 0, 0, 0, 0);
    // R3: add wrap to zero with carry, adc with carry in
    step(0, 1, 'hFFFF, 1, 5'b000_00, 0, 0);
    step(0, 1, 'hFFFF, 0, 5'b000_10, 0, 1);
    step(0, 1, 'h1234, 'h0101, 5'b000_10, 1, 0);
    // R4: equal subtract, borrow, sbc with and without carry
    step(0, 1, 5, 5, 5'b000_01, 0, 0);
    step(0, 1, 3, 5, 5'b000_01, 0, 1);
    step(0, 1, 5, 2, 5'b000_11, 0, 0);
    step(0, 1, 5, 2, 5'b000_11, 0, 1);
    step(0, 1, 0, 0, 5'b000_11, 0, 0);
    // R6: each condition true and false
    step(0, 1, 7, 1, 5'b001_00, 1, 0);
    step(0, 1, 7, 1, 5'b001_00, 0, 1);
    step(0, 1, 9, 4, 5'b010_01, 0, 0);
    step(0, 1, 9, 4, 5'b010_01, 1, 1);
    step(0, 1, 2, 3, 5'b011_00, 0, 1);
    step(0, 1, 2, 3, 5'b011_00, 1, 0);
    // R7: reserved conditions
    for (int c = 4; c < 8; c++) step(0, 1, 1, 1, (c << 2) | 1, c[0], c[1]);
    // R9: valid low on an always-run code
    step(0, 0, 'hAAAA, 'h5555, 5'b000_00, 1, 0);
    // R8: result hold after a skipped op, then reset mid-run (R1)
    step(0, 1, 1, 1, 5'b010_00, 1, 1);
    step(1, 1, 1, 1, 5'b000_00, 0, 0);
    // random sweep
    for (int i = 0; i < 3000; i++) begin
      int ra = $urandom & MASK;
      int rb = ($urandom_range(0, 7) == 0) ? ra : ($urandom & MASK);
      step(0, $urandom_range(0, 9) != 0, ra, rb, $urandom & 31,
           $urandom & 1, $urandom & 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule